// File: doc/BRIEF.md
# Two-Strobe DMA Channel Configuration Adapter

This block programs the registers of a two-channel byte DMA engine from an 8-bit byte stream. Every register byte costs two strobes of `cfg_valid`: a command byte that names the channel, the register and, for the 16-bit address registers, which half of the address; then the payload byte that is written there. The adapter holds each channel's source address, destination address, transfer length and the two address-increment flags. These values go straight to the DMA datapath.

The arm bit from a control payload is stored apart from the other control fields. A pulse on `start_strobe` turns each armed channel into a one-cycle start request and then disarms that channel. While a command is waiting for its payload, `cfg_pending` is high. A malformed command raises the sticky `cfg_error` flag.

Top module: `dma_cfg_adapter`

## Requirements
- R1: After reset every channel register, arm bit, start request, `cfg_pending` and `cfg_error` is zero.
- R2: Outside the pending state, a `cfg_valid` byte is a command. It is well formed when bit 7 is 1 and bits 3, 1 and 0 are 0, and bit 2 may be 1 only for the address registers. A well-formed command drives `cfg_pending` high from the next cycle. The next `cfg_valid` byte is always taken as its payload, whatever its value, and `cfg_pending` is low in the cycle after that byte.
- R3: For the source (command bits 5:4 = 00) and destination (01) registers, command bit 2 = 0 writes payload into address bits 7:0 and bit 2 = 1 writes bits 15:8. The other half of the address is left unchanged.
- R4: Register code 10 writes the 8-bit transfer length from the payload.
- R5: Register code 11 is the control register. Payload bit 0 is arm, bit 1 is source increment and bit 2 is destination increment. Payload bits 7:3 have no effect.
- R6: A command byte that is not well formed sets `cfg_error` in the next cycle. It leaves `cfg_pending` low and changes no register.
- R7: `cfg_error` stays set until reset or until a well-formed command is accepted. It reads low from the cycle in which `cfg_pending` rises.
- R8: A `start_strobe` pulse makes `start_req[n]` high for exactly the next cycle for each channel n that is armed, and for no other channel. The arm bit of each such channel is cleared in that same cycle, so a further strobe issues nothing until the channel is armed again.
- R9: Bytes presented while `cfg_valid` is low have no effect on any output.
- R10: Command bit 6 selects the channel: 0 for channel 0, 1 for channel 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_data | input | 8 | Command or payload byte |
| cfg_valid | input | 1 | Qualifies `cfg_data` for one cycle |
| start_strobe | input | 1 | Requests a start of every armed channel |
| src_addr | output | 2x16 | Source address per channel |
| dst_addr | output | 2x16 | Destination address per channel |
| xfer_len | output | 2x8 | Transfer length per channel |
| src_inc | output | 2 | Source increment flag per channel |
| dst_inc | output | 2 | Destination increment flag per channel |
| armed | output | 2 | Arm bit per channel |
| start_req | output | 2 | One-cycle start request per channel |
| cfg_pending | output | 1 | A command awaits its payload |
| cfg_error | output | 1 | Sticky malformed-command flag |

## Verification
On every cycle the assertions check the pending handshake: a command with bit 7 clear never leads to the pending state, and a payload always closes it. They also check that the error flag holds, that idle bytes leave the address registers untouched, and that a start request only follows a strobe on an armed channel, which is then disarmed. The exact landing place of each payload needs the bench's vector table against its own register model. So do the choice of byte lane, the rejection of the lane bit on length and control, and the fact that a command-looking payload is stored as data.

// File: rtl/dma_cfg_adapter.sv
module dma_cfg_adapter #(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [7:0]                   cfg_data,
  input  logic                         cfg_valid,
  input  logic                         start_strobe,
  output logic [1:0][ADDR_W-1:0]       src_addr,
  output logic [1:0][ADDR_W-1:0]       dst_addr,
  output logic [1:0][LEN_W-1:0]        xfer_len,
  output logic [1:0]                   src_inc,
  output logic [1:0]                   dst_inc,
  output logic [1:0]                   armed,
  output logic [1:0]                   start_req,
  output logic                         cfg_pending,
  output logic                         cfg_error
);
  localparam int NCH  = 2;
  localparam int HALF = ADDR_W / 2;

  logic       sel_ch, sel_hi;
  logic [1:0] sel_reg;

  wire is_cmd  = cfg_valid && !cfg_pending;
  wire is_pay  = cfg_valid &&  cfg_pending;
  wire lane_ok = !cfg_data[5] || !cfg_data[2];
  wire cmd_ok  = cfg_data[7] && !cfg_data[3] && cfg_data[1:0] == 2'b00 && lane_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_pending <= 1'b0;
      cfg_error   <= 1'b0;
      sel_ch      <= 1'b0;
      sel_reg     <= 2'b00;
      sel_hi      <= 1'b0;
    end else if (is_cmd) begin
      cfg_pending <= cmd_ok;
      cfg_error   <= !cmd_ok | (cfg_error & !cmd_ok);
      if (cmd_ok) begin
        sel_ch  <= cfg_data[6];
        sel_reg <= cfg_data[5:4];
        sel_hi  <= cfg_data[2];
      end
    end else if (is_pay) begin
      cfg_pending <= 1'b0;
    end
  end

  for (genvar gi = 0; gi < NCH; gi++) begin : g_ch
    wire hit = is_pay && (sel_ch == gi[0]);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        src_addr[gi]  <= '0;
        dst_addr[gi]  <= '0;
        xfer_len[gi]  <= '0;
        src_inc[gi]   <= 1'b0;
        dst_inc[gi]   <= 1'b0;
        armed[gi]     <= 1'b0;
        start_req[gi] <= 1'b0;
      end else begin
        start_req[gi] <= start_strobe & armed[gi];
        if (start_strobe) armed[gi] <= 1'b0;
        if (hit) begin
          case (sel_reg)
            2'b00: if (sel_hi) src_addr[gi][ADDR_W-1:HALF] <= cfg_data;
                   else        src_addr[gi][HALF-1:0]      <= cfg_data;
            2'b01: if (sel_hi) dst_addr[gi][ADDR_W-1:HALF] <= cfg_data;
                   else        dst_addr[gi][HALF-1:0]      <= cfg_data;
            2'b10: xfer_len[gi] <= cfg_data[LEN_W-1:0];
            default: begin
              armed[gi]   <= cfg_data[0];
              src_inc[gi] <= cfg_data[1];
              dst_inc[gi] <= cfg_data[2];
            end
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/dma_cfg_adapter_chk.sv
module dma_cfg_adapter_chk (
  input logic             clk,
  input logic             rst_n,
  input logic [7:0]       cfg_data,
  input logic             cfg_valid,
  input logic             start_strobe,
  input logic [1:0][15:0] src_addr,
  input logic [1:0][15:0] dst_addr,
  input logic [1:0]       armed,
  input logic [1:0]       start_req,
  input logic             cfg_pending,
  input logic             cfg_error
);
  AST_BAD_CMD_NO_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && !cfg_pending && !cfg_data[7]) |=> (cfg_error && !cfg_pending)); // R6

  AST_PAYLOAD_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && cfg_pending) |=> !cfg_pending); // R2

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_error && !(cfg_valid && !cfg_pending)) |=> cfg_error); // R7

  AST_ERR_LOW_ON_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_pending) |-> !cfg_error); // R7

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_valid && !cfg_pending) |=> ($stable(src_addr) && $stable(dst_addr))); // R9

  for (genvar gi = 0; gi < 2; gi++) begin : g_a
    AST_START_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
      start_req[gi] |-> ($past(armed[gi]) && $past(start_strobe))); // R8

    AST_START_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
      (start_strobe && armed[gi] && !(cfg_valid && cfg_pending)) |=> (start_req[gi] && !armed[gi])); // R8
  end
endmodule

bind dma_cfg_adapter dma_cfg_adapter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_data(cfg_data), .cfg_valid(cfg_valid),
  .start_strobe(start_strobe), .src_addr(src_addr), .dst_addr(dst_addr),
  .armed(armed), .start_req(start_req), .cfg_pending(cfg_pending),
  .cfg_error(cfg_error)
);

// File: tb/sim_dma_cfg_adapter.sv
module sim_dma_cfg_adapter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] cfg_data = 8'h00;
  logic cfg_valid = 1'b0;
  logic start_strobe = 1'b0;
  logic [1:0][15:0] src_addr, dst_addr;
  logic [1:0][7:0]  xfer_len;
  logic [1:0] src_inc, dst_inc, armed, start_req;
  logic cfg_pending, cfg_error;

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  dma_cfg_adapter u0 (
    .clk(clk), .rst_n(rst_n), .cfg_data(cfg_data), .cfg_valid(cfg_valid),
    .start_strobe(start_strobe), .src_addr(src_addr), .dst_addr(dst_addr),
    .xfer_len(xfer_len), .src_inc(src_inc), .dst_inc(dst_inc), .armed(armed),
    .start_req(start_req), .cfg_pending(cfg_pending), .cfg_error(cfg_error)
  );

  logic [15:0] m_src [2];
  logic [15:0] m_dst [2];
  logic [7:0]  m_len [2];
  logic [1:0]  m_si, m_di, m_arm;
  logic        m_err;

  // bit 16 = malformed command (sent alone), [15:8] command, [7:0] payload
  localparam int NV = 17;
  localparam logic [16:0] VEC [NV] = '{
    17'h0_8010, 17'h0_8400, 17'h0_9020, 17'h0_9400, 17'h0_A004, 17'h0_B007,
    17'h0_C0AB, 17'h0_C4CD, 17'h0_D0EF, 17'h0_D412, 17'h0_E0FF, 17'h0_F0FA,
    17'h1_0100, 17'h1_8800, 17'h1_A400, 17'h1_8200, 17'h0_8477
  };

  task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic send(logic [7:0] b);
    @(negedge clk);
    cfg_data  = b;
    cfg_valid = 1'b1;
    @(negedge clk);
    cfg_valid = 1'b0;
  endtask

  task automatic strobe();
    @(negedge clk);
    start_strobe = 1'b1;
    @(negedge clk);
    start_strobe = 1'b0;
  endtask

  task automatic model_write(logic [7:0] c, logic [7:0] p);
    int ch = int'(c[6]);
    case (c[5:4])
      2'b00: if (c[2]) m_src[ch][15:8] = p; else m_src[ch][7:0] = p;
      2'b01: if (c[2]) m_dst[ch][15:8] = p; else m_dst[ch][7:0] = p;
      2'b10: m_len[ch] = p;
      default: begin m_arm[ch] = p[0]; m_si[ch] = p[1]; m_di[ch] = p[2]; end
    endcase
  endtask

  task automatic compare_all(string tag);
    check(tag, {32'h0, src_addr}, {32'h0, m_src[1], m_src[0]});
    check(tag, {32'h0, dst_addr}, {32'h0, m_dst[1], m_dst[0]});
    check(tag, {48'h0, xfer_len}, {48'h0, m_len[1], m_len[0]});
    check(tag, {58'h0, src_inc, dst_inc, armed}, {58'h0, m_si, m_di, m_arm});
    check(tag, {62'h0, cfg_pending, cfg_error}, {62'h0, 1'b0, m_err});
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      mismatched++;
      $display("FAIL watchdog R1: actual %0d cycles expected completion", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 2; i++) begin
      m_src[i] = '0; m_dst[i] = '0; m_len[i] = '0;
    end
    m_si = '0; m_di = '0; m_arm = '0; m_err = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    compare_all("R1 reset state");
    check("R1 start_req after reset", {62'h0, start_req}, 64'h0);

    for (int v = 0; v < NV; v++) begin
      if (VEC[v][16]) begin
        send(VEC[v][15:8]);
        m_err = 1'b1;
        compare_all("R6 malformed command");
      end else begin
        send(VEC[v][15:8]);
        check("R2 R7 pending after command", {62'h0, cfg_pending, cfg_error}, {62'h0, 2'b10});
        m_err = 1'b0;
        send(VEC[v][7:0]);
        model_write(VEC[v][15:8], VEC[v][7:0]);
        compare_all("R3 R4 R5 R10 payload write");
      end
    end

    // R9: bytes without cfg_valid
    @(negedge clk); cfg_data = 8'hA0;
    @(negedge clk); cfg_data = 8'h55;
    @(negedge clk);
    compare_all("R9 idle bytes ignored");

    // R2: a command-looking payload is data
    send(8'hE0); send(8'h81);
    m_len[1] = 8'h81;
    compare_all("R2 payload 0x81 stored as length");

    // R7: error sticky, cleared by accepted command
    send(8'h41);
    m_err = 1'b1;
    repeat (3) @(negedge clk);
    check("R7 error held while idle", {63'h0, cfg_error}, 64'h1);
    send(8'hA0);
    check("R7 error cleared on accept", {62'h0, cfg_pending, cfg_error}, {62'h0, 2'b10});
    send(8'h09);
    m_len[0] = 8'h09; m_err = 1'b0;
    compare_all("R4 length after error clear");

    // R8: only armed channel 0 starts, then disarmed
    strobe();
    check("R8 start request ch0 only", {62'h0, start_req}, 64'h1);
    check("R8 arm cleared", {62'h0, armed}, 64'h0);
    @(negedge clk);
    check("R8 start is one cycle", {62'h0, start_req}, 64'h0);
    strobe();
    check("R8 no start without re-arm", {62'h0, start_req}, 64'h0);
    send(8'hB0); send(8'hF9);
    send(8'hF0); send(8'h01);
    check("R5 arm both, upper bits ignored", {58'h0, src_inc, dst_inc, armed}, {58'h0, 2'b00, 2'b00, 2'b11});
    strobe();
    check("R8 start both channels", {62'h0, start_req}, 64'h3);

    // R1: reset mid-command clears pending
    send(8'h80);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    check("R1 reset clears pending", {62'h0, cfg_pending, cfg_error}, 64'h0);
    check("R1 reset clears source", {32'h0, src_addr}, 64'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule